// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block is the interrupt core of a parallel interface controller. Seven event sources feed a seven-bit flag register. Four of them are external control lines, two per port, and each line has a programmable active edge. The other three are single-cycle pulses: shift-engine completion, the second timer's timeout and the first timer's timeout. A companion enable register selects which flags may raise the request. Bit 7 of the flag byte is a summary bit computed from the two registers, and the active-low request line follows that summary bit.

Flags clear through side effects of accesses to the port output registers and the shift register, or by writing ones into the flag register. The enable register is updated by a write whose bit 7 chooses whether the ones in bits 0-6 set or clear their enables.

Each control line passes through a two-flop synchroniser and then into a small level-tracking state machine. The machine has two states, `LVL_LOW` and `LVL_HIGH`. The transition `RISE` (from `LVL_LOW` to `LVL_HIGH`) fires when the synchronised level reads 1. The transition `FALL` (from `LVL_HIGH` to `LVL_LOW`) fires when it reads 0. A transition produces an edge event only when it matches the line's configured polarity. The machine resets into `LVL_LOW`.

Top module: `irq_flag_unit`

## Requirements
- R1: Flag positions are fixed by source. Bit 0 is the port A line 2 edge, bit 1 the port A line 1 edge, bit 2 `shift_done`, bit 3 the port B line 2 edge, bit 4 the port B line 1 edge, bit 5 `t2_expire` and bit 6 `t1_expire`.
- R2: Each line's polarity input selects its active edge: 1 selects rising and 0 selects falling. A transition in the other direction sets no flag.
- R3: When `acc_sel` = 3, `rd_data` returns the flags in bits 0-6. Bit 7 reads 1 exactly when some flag is set and its enable is also set.
- R4: `irq_n` is 0 exactly when the summary bit is 1.
- R5: A write with `acc_sel` = 4 updates the enables. If data bit 7 is 1, each 1 in bits 0-6 sets its enable. If data bit 7 is 0, each 1 clears its enable. Zeros leave enables unchanged.
- R6: When `acc_sel` = 4, `rd_data` returns 1 in bit 7 and the current enables in bits 0-6.
- R7: A read or write with `acc_sel` = 1 (port A output register) clears flags 0 and 1. A read or write with `acc_sel` = 0 (port B output register) clears flags 3 and 4.
- R8: With `a2_indep` = 1, a port A access leaves flag 0 set. With `b2_indep` = 1, a port B access leaves flag 3 set.
- R9: A read or write with `acc_sel` = 2 (shift register) clears flag 2.
- R10: A write with `acc_sel` = 3 clears each flag whose data bit is 1. A 0 data bit has no effect.
- R11: A set event in the same cycle as a clearing access leaves the flag set.
- R12: After reset, all flags and all enables are 0 and `irq_n` is 1.
- R13: A change on a control line sets its flag on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_a1 | input | 1 | Port A control line 1, asynchronous |
| ctl_a2 | input | 1 | Port A control line 2, asynchronous |
| ctl_b1 | input | 1 | Port B control line 1, asynchronous |
| ctl_b2 | input | 1 | Port B control line 2, asynchronous |
| a1_rise | input | 1 | Active edge of ctl_a1: 1 rising, 0 falling |
| a2_rise | input | 1 | Active edge of ctl_a2 |
| b1_rise | input | 1 | Active edge of ctl_b1 |
| b2_rise | input | 1 | Active edge of ctl_b2 |
| a2_indep | input | 1 | Port A line 2 flag ignores port A accesses |
| b2_indep | input | 1 | Port B line 2 flag ignores port B accesses |
| shift_done | input | 1 | One-cycle pulse: shift engine finished eight bits |
| t2_expire | input | 1 | One-cycle pulse: timer 2 timeout |
| t1_expire | input | 1 | One-cycle pulse: timer 1 timeout |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | Access is a write |
| acc_sel | input | 3 | Register selected: 0 port B out, 1 port A out, 2 shift, 3 flags, 4 enables |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for flags or enables, 0 otherwise |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the pulse sources and the access strobe are synchronous to `clk`. They also assume that each access lasts one cycle with its select and data stable. The bench drives every input on the falling edge, so all inputs are settled at the rising edge. The control lines are held low through reset, which keeps the edge machines from reporting a spurious `RISE` when reset ends. Each level change on a control line is held for at least four cycles, so the synchroniser never has to catch a glitch narrower than a clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 7;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int NUM_CTL = 4;

    localparam int BIT_A2 = 0;
    localparam int BIT_A1 = 1;
    localparam int BIT_SR = 2;
    localparam int BIT_B2 = 3;
    localparam int BIT_B1 = 4;
    localparam int BIT_T2 = 5;
    localparam int BIT_T1 = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_PORTB  = 3'd0,
        SEL_PORTA  = 3'd1,
        SEL_SHIFT  = 3'd2,
        SEL_FLAGS  = 3'd3,
        SEL_ENABLE = 3'd4
    } acc_sel_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic rise_active,
    output logic edge_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    lvl_state_e             state_q, state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl)  state_d = LVL_HIGH;   // RISE
            LVL_HIGH: if (!lvl) state_d = LVL_LOW;    // FALL
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        edge_pulse = 1'b0;
        unique case (state_q)
            LVL_LOW:  edge_pulse = lvl && rise_active;
            LVL_HIGH: edge_pulse = !lvl && !rise_active;
        endcase
    end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_pkg::*;
#(
    parameter int WIDTH = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flag_q
);
    // A set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
#(
    parameter int WIDTH = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             set_mode,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_en) begin
            if (set_mode) en_q <= en_q | mask;
            else          en_q <= en_q & ~mask;
        end
    end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_a1,
    input  logic              ctl_a2,
    input  logic              ctl_b1,
    input  logic              ctl_b2,
    input  logic              a1_rise,
    input  logic              a2_rise,
    input  logic              b1_rise,
    input  logic              b2_rise,
    input  logic              a2_indep,
    input  logic              b2_indep,
    input  logic              shift_done,
    input  logic              t2_expire,
    input  logic              t1_expire,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic [NUM_SRC-1:0] set_vec, clr_vec, flag_q, en_q;
    logic [NUM_CTL-1:0] line_vec, rise_vec, edge_vec;
    logic               hit_a, hit_b, hit_sr, wr_flags, wr_en, summary;
    acc_sel_e           sel;

    // Line order maps onto flag bits 0, 1, 3, 4
    assign line_vec = {ctl_b1, ctl_b2, ctl_a1, ctl_a2};
    assign rise_vec = {b1_rise, b2_rise, a1_rise, a2_rise};

    for (genvar i = 0; i < NUM_CTL; i++) begin : g_line
        localparam int POS = (i < 2) ? i : i + 1;
        irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_in     (line_vec[i]),
            .rise_active (rise_vec[i]),
            .edge_pulse  (edge_vec[i])
        );
        assign set_vec[POS] = edge_vec[i];
    end

    assign set_vec[BIT_SR] = shift_done;
    assign set_vec[BIT_T2] = t2_expire;
    assign set_vec[BIT_T1] = t1_expire;

    assign sel      = acc_sel_e'(acc_sel);
    assign hit_a    = acc_en && (sel == SEL_PORTA);
    assign hit_b    = acc_en && (sel == SEL_PORTB);
    assign hit_sr   = acc_en && (sel == SEL_SHIFT);
    assign wr_flags = acc_en && acc_wr && (sel == SEL_FLAGS);
    assign wr_en    = acc_en && acc_wr && (sel == SEL_ENABLE);

    always_comb begin
        clr_vec = wr_flags ? acc_wdata[NUM_SRC-1:0] : '0;
        if (hit_a) begin
            clr_vec[BIT_A1] = 1'b1;
            if (!a2_indep) clr_vec[BIT_A2] = 1'b1;
        end
        if (hit_b) begin
            clr_vec[BIT_B1] = 1'b1;
            if (!b2_indep) clr_vec[BIT_B2] = 1'b1;
        end
        if (hit_sr) clr_vec[BIT_SR] = 1'b1;
    end

    irq_flag_reg #(.WIDTH(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (flag_q)
    );

    irq_enable_reg #(.WIDTH(NUM_SRC)) u_enables (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .set_mode (acc_wdata[DATA_W-1]),
        .mask     (acc_wdata[NUM_SRC-1:0]),
        .en_q     (en_q)
    );

    assign summary = |(flag_q & en_q);
    assign irq_n   = !summary;

    always_comb begin
        rd_data = '0;
        if (sel == SEL_FLAGS)  rd_data = {summary, flag_q};
        if (sel == SEL_ENABLE) rd_data = {1'b1, en_q};
    end
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               acc_wr,
    input logic [SEL_W-1:0]   acc_sel,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic               a2_indep,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] set_vec
);
    a_r3_summary_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == SEL_FLAGS) |-> (rd_data[7] == |(flag_q & en_q)));

    a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|(flag_q & en_q)));

    a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_sel == SEL_ENABLE && acc_wdata[7])
        |=> en_q == ($past(en_q) | $past(acc_wdata[6:0])));

    a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_sel == SEL_ENABLE && !acc_wdata[7])
        |=> en_q == ($past(en_q) & ~$past(acc_wdata[6:0])));

    a_r6_enable_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == SEL_ENABLE) |-> (rd_data == {1'b1, en_q}));

    a_r7_porta_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_sel == SEL_PORTA && !set_vec[1]) |=> !flag_q[1]);

    a_r8_indep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_sel == SEL_PORTA && a2_indep && flag_q[0]) |=> flag_q[0]);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
endmodule

bind irq_flag_unit irq_flag_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .acc_wdata (acc_wdata),
    .a2_indep  (a2_indep),
    .rd_data   (rd_data),
    .irq_n     (irq_n),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .set_vec   (set_vec)
);

// File: tb/test_irq_flag_unit.sv
module test_irq_flag_unit;
    localparam logic [2:0] S_PB = 3'd0, S_PA = 3'd1, S_SR = 3'd2,
                           S_FL = 3'd3, S_EN = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_a1 = 0, ctl_a2 = 0, ctl_b1 = 0, ctl_b2 = 0;
    logic a1_rise = 1, a2_rise = 1, b1_rise = 1, b2_rise = 1;
    logic a2_indep = 0, b2_indep = 0;
    logic shift_done = 0, t2_expire = 0, t1_expire = 0;
    logic acc_en = 0, acc_wr = 0;
    logic [2:0] acc_sel = 3'd7;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_chk = 0, n_fail = 0;
    logic finished = 0;

    always #10 clk = ~clk;

    irq_flag_unit i_irq_flag_unit (
        .clk(clk), .rst_n(rst_n),
        .ctl_a1(ctl_a1), .ctl_a2(ctl_a2), .ctl_b1(ctl_b1), .ctl_b2(ctl_b2),
        .a1_rise(a1_rise), .a2_rise(a2_rise), .b1_rise(b1_rise), .b2_rise(b2_rise),
        .a2_indep(a2_indep), .b2_indep(b2_indep),
        .shift_done(shift_done), .t2_expire(t2_expire), .t1_expire(t1_expire),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] s, output logic [7:0] v);
        acc_sel = s;
        #1 v = rd_data;
    endtask

    task automatic access(input logic [2:0] s, input logic wr, input logic [7:0] d);
        acc_en = 1; acc_wr = wr; acc_sel = s; acc_wdata = d;
        tick(1);
        acc_en = 0; acc_wr = 0; acc_sel = 3'd7;
    endtask

    task automatic check_flags(input string req, input logic [7:0] exp);
        logic [7:0] v;
        peek(S_FL, v);
        check(req, v, exp);
        check({req, " irq_n"}, {7'd0, irq_n}, {7'd0, !exp[7]});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check_flags("R12 flags", 8'h00);
        peek(S_EN, v);
        check("R12/R6 enables", v, 8'h80);
    endtask

    task automatic t_sources;
        t1_expire = 1; tick(1); t1_expire = 0;
        check_flags("R1 t1 bit6", 8'h40);
        t2_expire = 1; tick(1); t2_expire = 0;
        shift_done = 1; tick(1); shift_done = 0;
        check_flags("R1 t2/shift bits5,2", 8'h64);
        ctl_a2 = 1; tick(4);
        check_flags("R1 a2 bit0", 8'h65);
        ctl_a1 = 1; ctl_b2 = 1; ctl_b1 = 1; tick(4);
        check_flags("R1 all sources", 8'h7F);
    endtask

    task automatic t_enables;
        logic [7:0] v;
        access(S_EN, 1, 8'hC2);
        peek(S_EN, v);
        check("R5/R6 set enables", v, 8'hC2);
        check_flags("R3/R4 summary on", 8'hFF);
        access(S_EN, 1, 8'h02);
        peek(S_EN, v);
        check("R5 clear enable", v, 8'hC0);
        access(S_EN, 1, 8'h80);
        peek(S_EN, v);
        check("R5 zeros no effect", v, 8'hC0);
        access(S_FL, 1, 8'h00);
        check_flags("R10 zero write", 8'hFF);
        access(S_FL, 1, 8'h40);
        check_flags("R10/R4 clear bit6", 8'h3F);
    endtask

    task automatic t_side_clear;
        access(S_PA, 0, 8'h00);
        check_flags("R7 port A read", 8'h3C);
        access(S_PB, 1, 8'h55);
        check_flags("R7 port B write", 8'h24);
        access(S_SR, 0, 8'h00);
        check_flags("R9 shift read", 8'h20);
        access(S_FL, 1, 8'h20);
        check_flags("R10 clear bit5", 8'h00);
    endtask

    task automatic t_indep;
        a2_indep = 1; b2_indep = 1;
        ctl_a2 = 0; ctl_b2 = 0; tick(4);
        check_flags("R2 falling ignored", 8'h00);
        ctl_a2 = 1; ctl_b2 = 1; tick(4);
        check_flags("R8 lines set", 8'h09);
        access(S_PA, 1, 8'h00);
        access(S_PB, 0, 8'h00);
        check_flags("R8 access keeps", 8'h09);
        access(S_FL, 1, 8'h09);
        check_flags("R8 write clears", 8'h00);
        a2_indep = 0; b2_indep = 0;
    endtask

    task automatic t_polarity;
        a1_rise = 0; b1_rise = 0; tick(1);
        check_flags("R2 cfg change no event", 8'h00);
        ctl_a1 = 0; ctl_b1 = 0; tick(4);
        check_flags("R2 falling active", 8'h12);
        access(S_FL, 1, 8'h12);
        ctl_a1 = 1; ctl_b1 = 1; tick(4);
        check_flags("R2 rising ignored", 8'h00);
        a1_rise = 1; b1_rise = 1;
    endtask

    task automatic t_set_wins;
        acc_en = 1; acc_sel = S_SR; shift_done = 1;
        tick(1);
        acc_en = 0; acc_sel = 3'd7; shift_done = 0;
        check_flags("R11 set beats clear", 8'h04);
        access(S_FL, 1, 8'h04);
    endtask

    task automatic t_latency;
        ctl_b1 = 0; tick(4);
        ctl_b1 = 1; tick(2);
        check_flags("R13 not yet", 8'h00);
        tick(1);
        check_flags("R13 third edge", 8'h10);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_sources();
        t_enables();
        t_side_clear();
        t_indep();
        t_polarity();
        t_set_wins();
        t_latency();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule